// File: doc/BRIEF.md
# Speculative Read-Set Snooping Cache

This block runs one speculative transaction for one core. While a transaction is open, each load that misses the local buffers takes its value from memory and records the line and that value in a read-set store. Stores never reach memory. They are held in a separate write buffer until commit. A load first looks for its own earlier store, then for a recorded read, and only then uses the memory value.

Remote write broadcasts are snooped against the read set. If one hits, the transaction is aborted. In one cycle the write buffer is emptied and the conflicting line is dropped from the read set. The other recorded reads stay, so the re-executed transaction gets their values without going to memory. A restart pulse follows the abort pulse at once. Commits are ordered by a token. After a commit strobe, the block waits until the token input is high. It then drives every buffered write onto the broadcast bus, one per cycle, and signals that the token may pass on.

Top module: `spec_txn_cache`

## Requirements
- R1: In the running state, a load to a line that is in neither store returns `mem_rdata` and records the line with that value. A later load to the same line returns the recorded value, whatever `mem_rdata` is then.
- R2: A store records the line and data in the write buffer, and a second store to the same line overwrites the data. A load to a buffered line returns the buffered data, ahead of any recorded read. Up to DEPTH (8) distinct lines are held.
- R3: The transaction is aborted and `ovf` is set when one of these would need a slot beyond DEPTH: a load of a new line when the read set is full, or a store to a new line when the write buffer is full. Both stores are then cleared. `ovf` stays high until the next begin, and it is low from the cycle after that begin.
- R4: A snoop (`snp_valid` with `snp_addr`) that matches a recorded read line, while running or waiting for the token, raises `abort` in the next cycle. A snoop that matches only a buffered write line, or no line, has no effect.
- R5: An abort empties the write buffer in the same edge. After the restart, a load to a line that was only written returns `mem_rdata`.
- R6: A snoop abort drops only the matching read line. Other recorded lines keep their values after the restart, and the dropped line is read from `mem_rdata` again.
- R7: `restart` is high for exactly the one cycle after the single `abort` cycle. The transaction is then running again and accepts accesses in that same cycle.
- R8: After `txn_commit`, no broadcast and no `tok_pass` occur while `tok_held` is low.
- R9: When the block is waiting and sees `tok_held` high in cycle T, it drives `bc_valid` in cycles T+1 to T+N, one buffered write per cycle. The writes come in the order in which their lines were first stored, each with its latest data.
- R10: `tok_pass` is high for one cycle. That cycle comes right after the last broadcast, or in T+1 if the buffer is empty. The block is then idle.
- R11: If an abort cause falls in the same cycle as `txn_commit`, or in the same cycle as `tok_held` while waiting, the abort wins: there is no broadcast and no `tok_pass`.
- R12: While idle, accesses, snoops, commits and the token are ignored, and a load returns `mem_rdata`. `txn_begin` opens a transaction with both stores empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_begin | input | 1 | Open a transaction (idle only) |
| txn_commit | input | 1 | Request commit of the running transaction |
| acc_valid | input | 1 | Core access strobe |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 16 | Line address of the access |
| acc_wdata | input | 16 | Store data |
| mem_rdata | input | 16 | Memory value for the accessed line |
| ld_data | output | 16 | Load result (combinational) |
| snp_valid | input | 1 | Remote write broadcast seen |
| snp_addr | input | 16 | Line address of the remote write |
| tok_held | input | 1 | Commit-order token is held by this core |
| bc_valid | output | 1 | Local broadcast write valid |
| bc_addr | output | 16 | Broadcast line address |
| bc_data | output | 16 | Broadcast data |
| tok_pass | output | 1 | Token may move to the next core |
| abort | output | 1 | Transaction aborted |
| restart | output | 1 | Re-execute the transaction |
| ovf | output | 1 | Capacity overflow caused the last abort |

## Verification
A conflicting snoop can arrive in the same cycle as the commit strobe. It can also arrive in the same cycle as the token while the block waits to commit. Both collisions are provoked with a store already buffered, so a wrong priority would show up as a broadcast. Each is judged by an abort in the next cycle, a restart one cycle later, and no `bc_valid` or `tok_pass` in the cycles that follow.

// File: rtl/spec_txn_pkg.sv
`timescale 1ns/1ps
package spec_txn_pkg;

    localparam int LINE_W = 16;
    localparam int WORD_W = 16;
    localparam int N_ENT  = 8;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        line_t line;
        word_t word;
    } slot_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_BCAST,
        ST_PASS,
        ST_ABORT
    } txn_state_e;

    function automatic int idx_width(int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/rdset_store.sv
`timescale 1ns/1ps
module rdset_store import spec_txn_pkg::*; #(
    parameter int DEPTH = N_ENT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_all,
    input  logic  kill_en,
    input  logic  alloc_en,
    input  line_t lk_line,
    input  word_t alloc_word,
    input  line_t snp_line,
    output logic  lk_hit,
    output word_t lk_word,
    output logic  full,
    output logic  snp_hit
);
    localparam int IDX_W = idx_width(DEPTH);

    slot_t            ent_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] lk_match;
    logic [DEPTH-1:0] snp_match;
    logic [IDX_W-1:0] free_idx;
    logic             free_ok;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            assign lk_match[g]  = vld_q[g] && (ent_q[g].line == lk_line);
            assign snp_match[g] = vld_q[g] && (ent_q[g].line == snp_line);
        end
    endgenerate

    always_comb begin
        lk_word  = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lk_match[i]) lk_word = ent_q[i].word;
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign lk_hit  = |lk_match;
    assign snp_hit = |snp_match;
    assign full    = &vld_q;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            vld_q <= '0;
        end else begin
            if (kill_en) vld_q <= vld_q & ~snp_match;
            if (alloc_en && free_ok) vld_q[free_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en && free_ok) ent_q[free_idx] <= '{line: lk_line, word: alloc_word};
    end

    // R1: a line is recorded at most once
    p_unique_read_line_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

endmodule

// File: rtl/wbuf_store.sv
`timescale 1ns/1ps
module wbuf_store import spec_txn_pkg::*; #(
    parameter int DEPTH = N_ENT,
    localparam int IDX_W = idx_width(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             wr_en,
    input  line_t            lk_line,
    input  word_t            wr_word,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             lk_hit,
    output word_t            lk_word,
    output logic             full,
    output logic [CNT_W-1:0] cnt,
    output slot_t            rd_slot
);
    slot_t            ent_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [DEPTH-1:0] match;
    logic [IDX_W-1:0] hit_idx;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = (CNT_W'(g) < cnt_q) && (ent_q[g].line == lk_line);
        end
    endgenerate

    always_comb begin
        lk_word = '0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                lk_word = ent_q[i].word;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign lk_hit  = |match;
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign cnt     = cnt_q;
    assign rd_slot = ent_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            cnt_q <= '0;
        end else if (wr_en && !lk_hit && !full) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (lk_hit) begin
                ent_q[hit_idx].word <= wr_word;
            end else if (!full) begin
                ent_q[cnt_q[IDX_W-1:0]] <= '{line: lk_line, word: wr_word};
            end
        end
    end

    // R2: a written line occupies one slot only
    p_unique_write_line_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R3: occupancy never exceeds the buffer depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/txn_ctrl.sv
`timescale 1ns/1ps
module txn_ctrl import spec_txn_pkg::*; #(
    parameter int DEPTH = N_ENT,
    localparam int IDX_W = idx_width(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             txn_begin,
    input  logic             txn_commit,
    input  logic             tok_held,
    input  logic             snp_valid,
    input  logic             snp_hit,
    input  logic             ovf_evt,
    input  logic [CNT_W-1:0] wcnt,
    output txn_state_e       state,
    output logic [IDX_W-1:0] bc_idx,
    output logic             run,
    output logic             abort_evt,
    output logic             clr_wbuf,
    output logic             clr_rset,
    output logic             kill_rset,
    output logic             abort,
    output logic             restart,
    output logic             tok_pass,
    output logic             bc_valid,
    output logic             ovf
);
    txn_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             restart_q;
    logic             ovf_q;
    logic             live;
    logic             conflict_evt;
    logic             open_evt;

    assign live         = (state_q == ST_RUN) || (state_q == ST_WAIT);
    assign conflict_evt = live && snp_valid && snp_hit;
    assign abort_evt    = conflict_evt || ovf_evt;
    assign open_evt     = (state_q == ST_IDLE) && txn_begin;

    assign run       = (state_q == ST_RUN);
    assign clr_wbuf  = open_evt || abort_evt;
    assign clr_rset  = open_evt || ovf_evt;
    assign kill_rset = conflict_evt;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (txn_begin) state_d = ST_RUN;
            ST_RUN: begin
                if (abort_evt)       state_d = ST_ABORT;
                else if (txn_commit) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (abort_evt)     state_d = ST_ABORT;
                else if (tok_held) state_d = (wcnt == '0) ? ST_PASS : ST_BCAST;
            end
            ST_BCAST: if (CNT_W'(idx_q) == wcnt - CNT_W'(1)) state_d = ST_PASS;
            ST_PASS:  state_d = ST_IDLE;
            ST_ABORT: state_d = ST_RUN;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            restart_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            restart_q <= (state_q == ST_ABORT);
            if (state_q == ST_BCAST) idx_q <= idx_q + IDX_W'(1);
            else                     idx_q <= '0;
            if (ovf_evt)       ovf_q <= 1'b1;
            else if (open_evt) ovf_q <= 1'b0;
        end
    end

    assign state    = state_q;
    assign bc_idx   = idx_q;
    assign abort    = (state_q == ST_ABORT);
    assign restart  = restart_q;
    assign tok_pass = (state_q == ST_PASS);
    assign bc_valid = (state_q == ST_BCAST);
    assign ovf      = ovf_q;

    // R4: a read-set hit while live aborts in the next cycle
    p_conflict_aborts_r4: assert property (@(posedge clk) disable iff (rst)
        (live && snp_valid && snp_hit) |=> abort);

    // R7: restart follows a single abort cycle
    p_restart_follows_abort_r7: assert property (@(posedge clk) disable iff (rst)
        abort |=> (restart && !abort));

    p_restart_needs_abort_r7: assert property (@(posedge clk) disable iff (rst)
        restart |-> $past(abort));

    // R8: broadcasting starts only after the token was seen
    p_bcast_after_token_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(bc_valid) |-> $past(tok_held));

    // R10: token passes after the last write or straight after the token
    p_pass_timing_r10: assert property (@(posedge clk) disable iff (rst)
        tok_pass |-> ($past(bc_valid) || $past(tok_held)));

    // R3: overflow flag rises together with an abort
    p_ovf_with_abort_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> abort);

endmodule

// File: rtl/spec_txn_cache.sv
`timescale 1ns/1ps
module spec_txn_cache import spec_txn_pkg::*; #(
    parameter int DEPTH = N_ENT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_begin,
    input  logic              txn_commit,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [LINE_W-1:0] acc_addr,
    input  logic [WORD_W-1:0] acc_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] ld_data,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_addr,
    input  logic              tok_held,
    output logic              bc_valid,
    output logic [LINE_W-1:0] bc_addr,
    output logic [WORD_W-1:0] bc_data,
    output logic              tok_pass,
    output logic              abort,
    output logic              restart,
    output logic              ovf
);
    localparam int IDX_W = idx_width(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    txn_state_e       state;
    logic [IDX_W-1:0] bc_idx;
    logic [CNT_W-1:0] wcnt;
    slot_t            bc_slot;
    logic             run, abort_evt, clr_wbuf, clr_rset, kill_rset;
    logic             rs_hit, rs_full, rs_snp_hit, wb_hit, wb_full;
    word_t            rs_word, wb_word;
    logic             ld_acc, st_acc, ovf_evt, rs_alloc, wb_wr;

    assign ld_acc = run && acc_valid && !acc_write;
    assign st_acc = run && acc_valid && acc_write;

    assign ovf_evt  = (ld_acc && !wb_hit && !rs_hit && rs_full)
                   || (st_acc && !wb_hit && wb_full);
    assign rs_alloc = ld_acc && !wb_hit && !rs_hit && !abort_evt;
    assign wb_wr    = st_acc && !abort_evt;

    rdset_store #(.DEPTH(DEPTH)) u_rset (
        .clk        (clk),
        .rst        (rst),
        .clr_all    (clr_rset),
        .kill_en    (kill_rset),
        .alloc_en   (rs_alloc),
        .lk_line    (acc_addr),
        .alloc_word (mem_rdata),
        .snp_line   (snp_addr),
        .lk_hit     (rs_hit),
        .lk_word    (rs_word),
        .full       (rs_full),
        .snp_hit    (rs_snp_hit)
    );

    wbuf_store #(.DEPTH(DEPTH)) u_wbuf (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clr_wbuf),
        .wr_en   (wb_wr),
        .lk_line (acc_addr),
        .wr_word (acc_wdata),
        .rd_idx  (bc_idx),
        .lk_hit  (wb_hit),
        .lk_word (wb_word),
        .full    (wb_full),
        .cnt     (wcnt),
        .rd_slot (bc_slot)
    );

    txn_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .txn_begin  (txn_begin),
        .txn_commit (txn_commit),
        .tok_held   (tok_held),
        .snp_valid  (snp_valid),
        .snp_hit    (rs_snp_hit),
        .ovf_evt    (ovf_evt),
        .wcnt       (wcnt),
        .state      (state),
        .bc_idx     (bc_idx),
        .run        (run),
        .abort_evt  (abort_evt),
        .clr_wbuf   (clr_wbuf),
        .clr_rset   (clr_rset),
        .kill_rset  (kill_rset),
        .abort      (abort),
        .restart    (restart),
        .tok_pass   (tok_pass),
        .bc_valid   (bc_valid),
        .ovf        (ovf)
    );

    always_comb begin
        if (!run)        ld_data = mem_rdata;
        else if (wb_hit) ld_data = wb_word;
        else if (rs_hit) ld_data = rs_word;
        else             ld_data = mem_rdata;
    end

    assign bc_addr = bc_valid ? bc_slot.line : '0;
    assign bc_data = bc_valid ? bc_slot.word : '0;

    // R5: the write buffer is already empty in the abort cycle
    p_wbuf_empty_on_abort_r5: assert property (@(posedge clk) disable iff (rst)
        abort |-> (wcnt == '0));

    // R12: an idle block never leaves idle except through begin
    p_idle_needs_begin_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !txn_begin) |=> (state == ST_IDLE));

endmodule

// File: tb/test_spec_txn_cache.sv
`timescale 1ns/1ps
module test_spec_txn_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        txn_begin = 1'b0, txn_commit = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [15:0] acc_addr = '0, acc_wdata = '0, mem_rdata = '0;
    logic [15:0] ld_data;
    logic        snp_valid = 1'b0;
    logic [15:0] snp_addr = '0;
    logic        tok_held = 1'b0;
    logic        bc_valid, tok_pass, abort, restart, ovf;
    logic [15:0] bc_addr, bc_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spec_txn_cache i_spec_txn_cache (
        .clk(clk), .rst(rst), .txn_begin(txn_begin), .txn_commit(txn_commit),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .mem_rdata(mem_rdata), .ld_data(ld_data),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .tok_held(tok_held),
        .bc_valid(bc_valid), .bc_addr(bc_addr), .bc_data(bc_data),
        .tok_pass(tok_pass), .abort(abort), .restart(restart), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        txn_begin = 1'b0; txn_commit = 1'b0; acc_valid = 1'b0; snp_valid = 1'b0;
    endtask

    task automatic look();
        #6;
    endtask

    task automatic ld(input logic [15:0] a, input logic [15:0] m, input logic [15:0] e, input string tag);
        step();
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; mem_rdata = m;
        look();
        chk(tag, ld_data, e);
    endtask

    task automatic st(input logic [15:0] a, input logic [15:0] d);
        step();
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        look();
    endtask

    task automatic open_txn();
        step();
        txn_begin = 1'b1;
        look();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    logic [15:0] ea [6];
    logic [15:0] ed [6];

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        look();
        chk("R12 reset abort", abort, 0);
        chk("R12 reset restart", restart, 0);
        chk("R12 reset bc_valid", bc_valid, 0);
        chk("R12 reset tok_pass", tok_pass, 0);
        chk("R12 reset ovf", ovf, 0);

        // R12: idle ignores everything
        step();
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 16'h0050; acc_wdata = 16'h0001;
        mem_rdata = 16'h4242; snp_valid = 1'b1; snp_addr = 16'h0050;
        txn_commit = 1'b1; tok_held = 1'b1;
        look();
        chk("R12 idle load", ld_data, 16'h4242);
        step(); look();
        chk("R12 idle abort", abort, 0);
        chk("R12 idle bc", bc_valid, 0);
        chk("R12 idle pass", tok_pass, 0);
        step(); look();
        chk("R12 idle bc2", bc_valid, 0);
        chk("R12 idle pass2", tok_pass, 0);
        tok_held = 1'b0;

        // R1: read set records values
        open_txn();
        for (int i = 0; i < 8; i++) ld(16'h0100 + 16'(i * 3), 16'hA000 + 16'(i), 16'hA000 + 16'(i), "R1 first load");
        for (int i = 0; i < 8; i++) ld(16'h0100 + 16'(i * 3), 16'h5555, 16'hA000 + 16'(i), "R1 reload");

        // R2: write buffer
        for (int i = 0; i < 5; i++) st(16'h0200 + 16'(i), 16'hC000 + 16'(i));
        st(16'h0202, 16'hDEAD);
        st(16'h0103, 16'h7777);
        for (int i = 0; i < 5; i++) ld(16'h0200 + 16'(i), 16'h1234, (i == 2) ? 16'hDEAD : 16'hC000 + 16'(i), "R2 buffered load");
        ld(16'h0103, 16'h1234, 16'h7777, "R2 write ahead of read");
        step(); look();
        chk("R3 no overflow on buffered hit", abort, 0);

        // R4: harmless snoops
        step(); snp_valid = 1'b1; snp_addr = 16'h0203; look();
        step(); look();
        chk("R4 write-only line snoop", abort, 0);
        step(); snp_valid = 1'b1; snp_addr = 16'h0FFF; look();
        step(); look();
        chk("R4 unrelated snoop", abort, 0);

        // R8/R9/R10: commit waits for token then broadcasts
        ea[0] = 16'h0200; ed[0] = 16'hC000;
        ea[1] = 16'h0201; ed[1] = 16'hC001;
        ea[2] = 16'h0202; ed[2] = 16'hDEAD;
        ea[3] = 16'h0203; ed[3] = 16'hC003;
        ea[4] = 16'h0204; ed[4] = 16'hC004;
        ea[5] = 16'h0103; ed[5] = 16'h7777;
        step(); txn_commit = 1'b1; look();
        for (int k = 0; k < 4; k++) begin
            step(); look();
            chk("R8 no bc without token", bc_valid, 0);
            chk("R8 no pass without token", tok_pass, 0);
        end
        step(); tok_held = 1'b1; look();
        chk("R9 not yet", bc_valid, 0);
        for (int e = 0; e < 6; e++) begin
            step(); look();
            chk("R9 bc_valid", bc_valid, 1);
            chk("R9 bc_addr", bc_addr, ea[e]);
            chk("R9 bc_data", bc_data, ed[e]);
        end
        step(); look();
        chk("R10 pass after last", tok_pass, 1);
        chk("R10 bus quiet", bc_valid, 0);
        tok_held = 1'b0;
        step(); look();
        chk("R10 pass one cycle", tok_pass, 0);

        // R9/R10 sweep over every fill level
        for (int n = 0; n <= 8; n++) begin
            open_txn();
            for (int j = 0; j < n; j++) st(16'h0300 + 16'(j), 16'h9000 + 16'(n * 16 + j));
            step(); txn_commit = 1'b1; look();
            step(); tok_held = 1'b1; look();
            for (int j = 0; j < n; j++) begin
                step(); look();
                chk("R9 sweep valid", bc_valid, 1);
                chk("R9 sweep addr", bc_addr, 16'h0300 + 16'(j));
                chk("R9 sweep data", bc_data, 16'h9000 + 16'(n * 16 + j));
            end
            step(); look();
            chk("R10 sweep pass", tok_pass, 1);
            chk("R10 sweep quiet", bc_valid, 0);
            tok_held = 1'b0;
            step(); look();
            chk("R10 sweep single", tok_pass, 0);
        end

        // R3: read-set overflow
        open_txn();
        for (int i = 0; i < 8; i++) ld(16'h0600 + 16'(i), 16'(i), 16'(i), "R1 fill");
        step(); acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 16'h0608; mem_rdata = 16'h0009; look();
        step(); look();
        chk("R3 read overflow abort", abort, 1);
        chk("R3 read overflow flag", ovf, 1);
        step(); look();
        chk("R7 restart after overflow", restart, 1);
        chk("R3 flag held", ovf, 1);
        ld(16'h0600, 16'h0BAD, 16'h0BAD, "R3 read set cleared");
        step(); txn_commit = 1'b1; tok_held = 1'b1; look();
        step(); look();
        step(); look();
        chk("R10 empty pass", tok_pass, 1);
        tok_held = 1'b0;
        open_txn();
        step(); look();
        chk("R3 flag cleared by begin", ovf, 0);

        // R3: write-buffer overflow
        for (int i = 0; i < 8; i++) st(16'h0700 + 16'(i), 16'(i));
        st(16'h0703, 16'hAAAA);
        step(); look();
        chk("R2 overwrite when full", abort, 0);
        st(16'h0708, 16'h0008);
        step(); look();
        chk("R3 write overflow abort", abort, 1);
        chk("R3 write overflow flag", ovf, 1);
        step(); look();
        chk("R7 restart", restart, 1);
        ld(16'h0703, 16'h0C0C, 16'h0C0C, "R5 buffer cleared");
        step(); txn_commit = 1'b1; tok_held = 1'b1; look();
        step(); look();
        step(); look();
        chk("R10 pass", tok_pass, 1);
        tok_held = 1'b0;

        // R4/R5/R6/R7: snoop conflict
        open_txn();
        ld(16'h0400, 16'h1111, 16'h1111, "R1 load");
        ld(16'h0401, 16'h2222, 16'h2222, "R1 load");
        st(16'h0500, 16'h3333);
        ld(16'h0500, 16'h0000, 16'h3333, "R2 own write");
        step(); snp_valid = 1'b1; snp_addr = 16'h0400; look();
        chk("R4 no abort yet", abort, 0);
        step(); look();
        chk("R4 conflict abort", abort, 1);
        chk("R7 no early restart", restart, 0);
        step();
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 16'h0401; mem_rdata = 16'hFFFF;
        look();
        chk("R7 restart", restart, 1);
        chk("R7 abort single", abort, 0);
        chk("R6 kept read", ld_data, 16'h2222);
        step(); look();
        chk("R7 restart single", restart, 0);
        ld(16'h0500, 16'hEEEE, 16'hEEEE, "R5 write dropped");
        ld(16'h0400, 16'hABCD, 16'hABCD, "R6 conflict line reloaded");

        // R11: abort against commit in the same cycle
        st(16'h0510, 16'h4444);
        step();
        txn_commit = 1'b1; tok_held = 1'b1; snp_valid = 1'b1; snp_addr = 16'h0401;
        look();
        step(); look();
        chk("R11 abort beats commit", abort, 1);
        chk("R11 no bc", bc_valid, 0);
        step(); look();
        chk("R11 restart", restart, 1);
        chk("R11 no bc 2", bc_valid, 0);
        step(); look();
        chk("R11 no bc 3", bc_valid, 0);
        chk("R11 no pass", tok_pass, 0);
        tok_held = 1'b0;

        // R11: abort against token while waiting
        st(16'h0510, 16'h4444);
        step(); txn_commit = 1'b1; look();
        step(); tok_held = 1'b1; snp_valid = 1'b1; snp_addr = 16'h0400; look();
        step(); look();
        chk("R11 abort beats token", abort, 1);
        chk("R11 wait no bc", bc_valid, 0);
        step(); look();
        chk("R11 wait restart", restart, 1);
        chk("R11 wait no bc 2", bc_valid, 0);
        chk("R11 wait no pass", tok_pass, 0);
        step(); txn_commit = 1'b1; look();
        step(); look();
        step(); look();
        chk("R10 final pass", tok_pass, 1);
        tok_held = 1'b0;

        step();
        summary();
        $finish;
    end

endmodule